// File: doc/BRIEF.md
# Split-Half 36-bit Adder/Subtractor

This block adds or subtracts two 36-bit two's-complement words, each a sign bit over 35 data bits. The word is not summed in one wide carry chain. It is handled as two 18-bit halves in two 20-bit lanes.

In the low lane, the 18 data bits sit in the upper positions and two guard bits sit below them. The guard bits turn the subtract carry-in into a carry into the lowest data bit. In the high lane, the 18 data bits sit in the lower positions and two copies of the sign sit above them. Those copies give the true sign of the result, and the two carry flags are derived from it.

A split control cuts the carry from the low lane into the high lane. Each half then wraps on its own, which gives half-word arithmetic. Subtraction adds the bitwise complement of the second operand plus one. In split mode, each half receives its own plus-one.

The result, the carry out of the sign position, the carry into the sign position and an integer-overflow flag are captured on the clock edge that samples the input strobe. A one-cycle done pulse marks them.

The sequencer has two states:
- `ST_IDLE`: no fresh result.
- `ST_DONE`: a result was captured on the previous edge.

It has two transitions:
- "strobe": any state goes to `ST_DONE` when `in_valid` is high.
- "no strobe": any state goes to `ST_IDLE` when `in_valid` is low.

Top module: `split36_addsub`

## Requirements
- R1: While `rst_n` is low and after reset, `done_o`, `result_o`, `cry_out_o`, `cry_in_o` and `ovf_o` are all 0.
- R2: `done_o` is high in exactly the cycle after a cycle in which `in_valid` was high on the clock edge, and low otherwise.
- R3: With `split_en`=0 and `sub_sel`=0, `result_o` equals (`op_a` + `op_b`) mod 2^36.
- R4: With `split_en`=0 and `sub_sel`=1, `result_o` equals (`op_a` − `op_b`) mod 2^36, formed as `op_a` + ~`op_b` + 1.
- R5: `cry_out_o` is the carry out of bit 35 of the 36-bit sum `op_a` + B' + cin. B' is `op_b`, complemented when subtracting, and cin equals `sub_sel`. For subtraction, this flag is 1 when no borrow occurs.
- R6: `cry_in_o` is the carry into bit 35, which is the carry out of bit 34, of the same sum.
- R7: `ovf_o` is 1 exactly when the true signed result leaves the 36-bit range. This happens when both effective operands are non-negative and the result looks negative, or both are negative and the result looks non-negative. It equals `cry_out_o` XOR `cry_in_o`. `ovf_o` is never 1 when the effective operand signs differ.
- R8: With `split_en`=1, `result_o[17:0]` = (`op_a[17:0]` ± `op_b[17:0]`) mod 2^18 and `result_o[35:18]` = (`op_a[35:18]` ± `op_b[35:18]`) mod 2^18. No carry crosses between bit 17 and bit 18.
- R9: With `split_en`=1, the three flags follow R5 to R7 applied to the 18-bit high half alone, with sign bit 35 and carry-in `sub_sel`.
- R10: When `in_valid` is low, `result_o` and all flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: operands valid this cycle |
| op_a | input | 36 | First operand |
| op_b | input | 36 | Second operand |
| sub_sel | input | 1 | 1 = subtract `op_b` from `op_a` |
| split_en | input | 1 | 1 = cut the carry between the halves |
| done_o | output | 1 | One-cycle pulse with a new result |
| result_o | output | 36 | Registered result |
| cry_out_o | output | 1 | Carry out of the sign position |
| cry_in_o | output | 1 | Carry into the sign position |
| ovf_o | output | 1 | Integer overflow |

## Verification
Every operation appears at the ports one cycle after its strobe, so any fault in a lane, guard bit or the inter-half carry mux shows up on that same capture. A broken guard-bit setup corrupts only subtraction and leaves the lowest data bit off by one. A stuck inter-half carry shows as an error of 2^18 in unsplit mode, or as leakage into the high half in split mode. A wrong sign-extension bit in the high lane corrupts the carry-out and overflow flags while the result stays correct. This is why the flags are checked against a signed 37-bit model rather than against each other.

// File: rtl/split36_pkg.sv
package split36_pkg;
    localparam int WORD_W  = 36;
    localparam int HALF_W  = WORD_W / 2;
    localparam int GUARD_W = 2;
    localparam int LANE_W  = HALF_W + GUARD_W;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic cry_out;
        logic cry_in;
        logic ovf;
    } flag_t;
endpackage

// File: rtl/split36_operand_prep.sv
module split36_operand_prep #(
    parameter int HALF_W  = 18,
    parameter int GUARD_W = 2,
    localparam int WORD_W = 2 * HALF_W,
    localparam int LANE_W = HALF_W + GUARD_W
) (
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              sub_sel,
    output logic [LANE_W-1:0] lo_a,
    output logic [LANE_W-1:0] lo_b,
    output logic [LANE_W-1:0] hi_a,
    output logic [LANE_W-1:0] hi_b,
    output logic              a_sign,
    output logic              b_sign
);
    logic [WORD_W-1:0] b_eff;

    // Complement the second operand bit by bit when subtracting.
    for (genvar i = 0; i < WORD_W; i++) begin : g_inv
        assign b_eff[i] = op_b[i] ^ sub_sel;
    end

    // Low lane: data in the upper positions. Guard bits of A are all ones, so a
    // carry-in of 1 ripples through them into the lowest data bit.
    assign lo_a = {op_a[HALF_W-1:0], {GUARD_W{1'b1}}};
    assign lo_b = {b_eff[HALF_W-1:0], {GUARD_W{1'b0}}};

    // High lane: data in the lower positions, sign copied into the extra bits.
    assign hi_a = {{GUARD_W{op_a[WORD_W-1]}}, op_a[WORD_W-1:HALF_W]};
    assign hi_b = {{GUARD_W{b_eff[WORD_W-1]}}, b_eff[WORD_W-1:HALF_W]};

    assign a_sign = op_a[WORD_W-1];
    assign b_sign = b_eff[WORD_W-1];
endmodule

// File: rtl/split36_lane_adder.sv
module split36_lane_adder #(
    parameter int W = 20
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] full;

    assign full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    assign sum  = full[W-1:0];
    assign cout = full[W];
endmodule

// File: rtl/split36_flag_unit.sv
module split36_flag_unit #(
    parameter int HALF_W  = 18,
    parameter int GUARD_W = 2,
    localparam int LANE_W = HALF_W + GUARD_W
) (
    input  logic [LANE_W-1:0] hi_sum,
    input  logic              a_sign,
    input  logic              b_sign,
    output split36_pkg::flag_t flags
);
    logic true_sign;
    logic vis_sign;

    // The first extension bit holds the true sign. The top data bit holds the
    // sign the result shows.
    assign true_sign = hi_sum[HALF_W];
    assign vis_sign  = hi_sum[HALF_W-1];

    always_comb begin
        flags.cry_out = true_sign ^ a_sign ^ b_sign;
        flags.cry_in  = vis_sign ^ a_sign ^ b_sign;
        flags.ovf     = true_sign ^ vis_sign;
    end
endmodule

// File: rtl/split36_addsub.sv
module split36_addsub
    import split36_pkg::*;
#(
    parameter int HALF_W  = split36_pkg::HALF_W,
    parameter int GUARD_W = split36_pkg::GUARD_W,
    localparam int WORD_W = 2 * HALF_W,
    localparam int LANE_W = HALF_W + GUARD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              sub_sel,
    input  logic              split_en,
    output logic              done_o,
    output logic [WORD_W-1:0] result_o,
    output logic              cry_out_o,
    output logic              cry_in_o,
    output logic              ovf_o
);
    logic [LANE_W-1:0] lo_a, lo_b, hi_a, hi_b, lo_sum, hi_sum;
    logic              a_sign, b_sign, lo_cout, hi_cout, hi_cin;
    logic [WORD_W-1:0] result_d;
    flag_t             flags_d;
    seq_state_t        state_q, state_d;

    split36_operand_prep #(.HALF_W(HALF_W), .GUARD_W(GUARD_W)) prep_i (
        .op_a(op_a), .op_b(op_b), .sub_sel(sub_sel),
        .lo_a(lo_a), .lo_b(lo_b), .hi_a(hi_a), .hi_b(hi_b),
        .a_sign(a_sign), .b_sign(b_sign)
    );

    split36_lane_adder #(.W(LANE_W)) lo_lane_i (
        .a(lo_a), .b(lo_b), .cin(sub_sel), .sum(lo_sum), .cout(lo_cout)
    );

    // When split, the high lane takes its own plus-one for subtraction.
    assign hi_cin = split_en ? sub_sel : lo_cout;

    split36_lane_adder #(.W(LANE_W)) hi_lane_i (
        .a(hi_a), .b(hi_b), .cin(hi_cin), .sum(hi_sum), .cout(hi_cout)
    );

    split36_flag_unit #(.HALF_W(HALF_W), .GUARD_W(GUARD_W)) flag_i (
        .hi_sum(hi_sum), .a_sign(a_sign), .b_sign(b_sign), .flags(flags_d)
    );

    assign result_d = {hi_sum[HALF_W-1:0], lo_sum[LANE_W-1:GUARD_W]};

    // Sequencer: the state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = in_valid ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o  <= '0;
            cry_out_o <= 1'b0;
            cry_in_o  <= 1'b0;
            ovf_o     <= 1'b0;
        end else if (in_valid) begin
            result_o  <= result_d;
            cry_out_o <= flags_d.cry_out;
            cry_in_o  <= flags_d.cry_in;
            ovf_o     <= flags_d.ovf;
        end
    end

    assign done_o = (state_q == ST_DONE);

    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done_o); // R2
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !done_o); // R2
    AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result_o) && $stable(cry_out_o) && $stable(cry_in_o) && $stable(ovf_o))); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_a[WORD_W-1] != (op_b[WORD_W-1] ^ sub_sel))) |=> !ovf_o); // R7
    AST_SPLIT_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && split_en) |=> (result_o[HALF_W-1:0] == ($past(sub_sel)
            ? ($past(op_a[HALF_W-1:0]) - $past(op_b[HALF_W-1:0]))
            : ($past(op_a[HALF_W-1:0]) + $past(op_b[HALF_W-1:0]))))); // R8
endmodule

// File: tb/split36_addsub_tb_top.sv
`timescale 1ns/1ps
module split36_addsub_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [35:0] op_a = '0, op_b = '0;
    logic        sub_sel = 1'b0, split_en = 1'b0;
    logic        done_o, cry_out_o, cry_in_o, ovf_o;
    logic [35:0] result_o;
    int          errors = 0, checks = 0;

    always #2 clk = ~clk;

    split36_addsub dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .sub_sel(sub_sel), .split_en(split_en), .done_o(done_o), .result_o(result_o),
        .cry_out_o(cry_out_o), .cry_in_o(cry_in_o), .ovf_o(ovf_o)
    );

    // Returns {cry_out, cry_in, ovf, result}
    function automatic logic [38:0] model(logic [35:0] a, logic [35:0] b, logic s, logic sp);
        logic [35:0] bx;
        logic [36:0] s37, sa, sb, r37;
        logic [35:0] t36;
        logic [18:0] s19, ha, hb, r19;
        logic [17:0] t18, lo;
        logic co, ci, ov;
        logic [35:0] res;
        bx = b ^ {36{s}};
        if (!sp) begin
            s37 = {1'b0, a} + {1'b0, bx} + {36'd0, s};
            t36 = {1'b0, a[34:0]} + {1'b0, bx[34:0]} + {35'd0, s};
            sa = {a[35], a};
            sb = s ? -{b[35], b} : {b[35], b};
            r37 = sa + sb;
            res = s37[35:0];
            co = s37[36];
            ci = t36[35];
            ov = r37[36] != r37[35];
        end else begin
            s19 = {1'b0, a[35:18]} + {1'b0, bx[35:18]} + {18'd0, s};
            t18 = {1'b0, a[34:18]} + {1'b0, bx[34:18]} + {17'd0, s};
            ha = {a[35], a[35:18]};
            hb = s ? -{b[35], b[35:18]} : {b[35], b[35:18]};
            r19 = ha + hb;
            lo = s ? (a[17:0] - b[17:0]) : (a[17:0] + b[17:0]);
            res = {s19[17:0], lo};
            co = s19[18];
            ci = t18[17];
            ov = r19[18] != r19[17];
        end
        return {co, ci, ov, res};
    endfunction

    task automatic check(string req, logic [38:0] act, logic [38:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One operation: strobe, check capture and done, then check that it holds.
    task automatic run_op(logic [35:0] a, logic [35:0] b, logic s, logic sp, string req);
        logic [38:0] exp, got;
        exp = model(a, b, s, sp);
        @(negedge clk);
        op_a = a; op_b = b; sub_sel = s; split_en = sp; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        got = {cry_out_o, cry_in_o, ovf_o, result_o};
        check(req, got, exp);
        check("R2 done pulse", {38'd0, done_o}, 39'd1);
        op_a = ~a; op_b = a ^ b; sub_sel = ~s; split_en = ~sp;
        @(negedge clk);
        check("R10 hold", {cry_out_o, cry_in_o, ovf_o, result_o}, exp);
        check("R2 done low", {38'd0, done_o}, 39'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int seed;
        logic [35:0] ra, rb;
        seed = 32'h5A17;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check("R1 reset", {done_o, cry_out_o, cry_in_o, ovf_o, result_o[34:0]}, 39'd0);
        check("R1 reset msb", {38'd0, result_o[35]}, 39'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {done_o, cry_out_o, cry_in_o, ovf_o, result_o[34:0]}, 39'd0);

        run_op(36'd0, 36'd0, 1'b0, 1'b0, "R3 zero");
        run_op(36'h7_FFFF_FFFF, 36'd1, 1'b0, 1'b0, "R7 R6 pos overflow");
        run_op(36'h8_0000_0000, 36'h8_0000_0000, 1'b0, 1'b0, "R7 R5 neg overflow");
        run_op(36'hF_FFFF_FFFF, 36'd1, 1'b0, 1'b0, "R5 R6 wrap no ovf");
        run_op(36'd0, 36'd0, 1'b1, 1'b0, "R4 R5 zero minus zero");
        run_op(36'd5, 36'd7, 1'b1, 1'b0, "R4 borrow");
        run_op(36'h8_0000_0000, 36'd1, 1'b1, 1'b0, "R7 R4 sub overflow");
        run_op(36'h0_0003_FFFF, 36'd1, 1'b0, 1'b0, "R3 carry across halves");
        run_op(36'h0_0003_FFFF, 36'd1, 1'b0, 1'b1, "R8 split no carry");
        run_op(36'h0_0000_0000, 36'h0_0004_0001, 1'b1, 1'b1, "R8 R9 split sub");
        run_op(36'h7_FFFC_0000, 36'h0_0004_0000, 1'b0, 1'b1, "R9 split hi overflow");
        run_op(36'h8_0000_0000, 36'h0_0004_0000, 1'b1, 1'b1, "R9 split hi sub overflow");

        for (int i = 0; i < 400; i++) begin
            ra = {$urandom(), $urandom()};
            rb = {$urandom(), $urandom()};
            if (i % 5 == 0) rb[35] = ra[35];
            run_op(ra, rb, 1'($urandom()), 1'($urandom()), "R3 R4 R5 R6 R7 R8 R9 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule